// File: doc/BRIEF.md
# Vertical Handover Decider

This block decides when a dual-network terminal should move its link between a wide-area network and a local-area network. Each evaluation is started by a one-cycle request. The block captures a snapshot of the measurements and then runs three stages, one per clock. The first stage is a trigger that compares the received signal strength of the two networks. The second is a fast veto that depends on which way the move would go. The third is a weighted score in which each of six link parameters gives its points to whichever network is better on it.

When the other network's score is strictly higher, the block issues a one-cycle handover command and updates its current-network register in the same edge. When the veto stage rejects a triggered move, the block issues a one-cycle cancel indication. The weights for data rate, delay and jitter come from an application class. The power-consumption weight rises as the battery drains. Measurement gathering and the physical-layer swap itself happen outside this block.

Top module: `handover_decider`

## Requirements
- R1: While on the wide-area network (on_local = 0), an evaluation triggers only when rss_local is strictly greater than rss_wide. Otherwise it produces neither ho_cmd nor ho_cancel.
- R2: When a move from wide to local triggers and speed is strictly above LOCAL_MAX_SPEED (default 60), ho_cancel pulses. A speed equal to the limit does not veto.
- R3: While on the local-area network (on_local = 1), an evaluation triggers only when rss_wide is strictly greater than rss_local. Equal strengths produce no output.
- R4: A triggered move from local to wide goes on to scoring only if battery < BATT_LOW (default 64) and rss_local < LOCAL_RSS_LIMIT (default 40). Otherwise ho_cancel pulses. Speed has no effect in this direction.
- R5: Scoring uses local_better: bit 0 is data rate, bit 1 delay, bit 2 jitter, bit 3 SNR, bit 4 BER and bit 5 power. A 1 gives that weight to the local network and a 0 gives it to the wide network. If the other network's total is strictly higher, ho_cmd pulses and on_local toggles.
- R6: If the scores tie or the current network leads, neither output pulses and on_local stays unchanged.
- R7: app_class selects the data-rate, delay and jitter weights: 0 gives 3/4/3, 1 gives 3/4/4, 2 gives 4/4/4, 3 gives 2/2/1 and 4 gives 1/1/1. Codes 5 to 7 behave like 0. The SNR and BER weights are always 3.
- R8: The power weight is 5 when battery >= 128, 7 when 64 <= battery < 128, and 9 when battery < 64.
- R9: Inputs are sampled at the clock edge where eval_start is seen. Any ho_cmd or ho_cancel pulse appears after the third edge that follows and lasts exactly one cycle. on_local changes in the same edge as ho_cmd.
- R10: An eval_start that arrives while an evaluation is in progress is ignored.
- R11: After reset, on_local = 0, ho_cmd = 0 and ho_cancel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_start | input | 1 | Starts an evaluation when the block is idle |
| rss_wide | input | 8 | Received strength of the wide-area network |
| rss_local | input | 8 | Received strength of the local-area network |
| speed | input | 8 | Device speed |
| battery | input | 8 | Battery level, 0 to 255 |
| local_better | input | 6 | Per-parameter comparison, 1 = local network better |
| app_class | input | 3 | Application class selecting the weight set |
| on_local | output | 1 | Current network, 1 = local-area |
| ho_cmd | output | 1 | One-cycle handover command |
| ho_cancel | output | 1 | One-cycle veto indication |

## Verification
Every result is due at a fixed latency. If eval_start is seen at edge k, any ho_cmd or ho_cancel pulse and the new on_local value are visible between edge k+3 and edge k+4. The bench drives inputs on falling edges and samples on falling edges. For each evaluation it checks that both pulses are still low after edge k+2, that the expected pulse and network are present after edge k+3, and that both pulses are low again after edge k+4. The busy-window test holds the request high through edges k to k+2 and counts cancel pulses over the following cycles, so that a request accepted in error would show up as a second pulse.

// File: rtl/hv_pkg.sv
package hv_pkg;

    localparam int MW       = 8;
    localparam int METRIC_N = 6;
    localparam int WEIGHT_W = 4;
    localparam int SCORE_W  = 6;

    typedef enum logic {
        NET_WIDE  = 1'b0,
        NET_LOCAL = 1'b1
    } net_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRIG,
        ST_VETO,
        ST_SCORE
    } state_e;

    typedef enum logic [2:0] {
        CLS_DEFAULT = 3'd0,
        CLS_VOICE   = 3'd1,
        CLS_VIDEO   = 3'd2,
        CLS_BROWSE  = 3'd3,
        CLS_IDLE    = 3'd4
    } app_e;

    typedef struct packed {
        logic [MW-1:0]       rss_wide;
        logic [MW-1:0]       rss_local;
        logic [MW-1:0]       speed;
        logic [MW-1:0]       battery;
        logic [METRIC_N-1:0] local_better;
        app_e                cls;
    } sample_t;

    // metric index order: rate, delay, jitter, snr, ber, power
    function automatic logic [WEIGHT_W-1:0] metric_weight(
        input int unsigned    idx,
        input app_e           cls,
        input logic [MW-1:0]  batt
    );
        logic [WEIGHT_W-1:0] w;
        logic [MW-1:0] quarter;
        logic [MW-1:0] half;
        quarter = MW'(1) << (MW - 2);
        half    = MW'(1) << (MW - 1);
        case (idx)
            0: case (cls)
                   CLS_VIDEO:  w = 4'd4;
                   CLS_BROWSE: w = 4'd2;
                   CLS_IDLE:   w = 4'd1;
                   default:    w = 4'd3;
               endcase
            1: case (cls)
                   CLS_BROWSE: w = 4'd2;
                   CLS_IDLE:   w = 4'd1;
                   default:    w = 4'd4;
               endcase
            2: case (cls)
                   CLS_VOICE:  w = 4'd4;
                   CLS_VIDEO:  w = 4'd4;
                   CLS_BROWSE: w = 4'd1;
                   CLS_IDLE:   w = 4'd1;
                   default:    w = 4'd3;
               endcase
            3: w = 4'd3;
            4: w = 4'd3;
            5: begin
                   if (batt < quarter)   w = 4'd9;
                   else if (batt < half) w = 4'd7;
                   else                  w = 4'd5;
               end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hv_trigger.sv
module hv_trigger
    import hv_pkg::*;
#(
    parameter int W = MW
) (
    input  net_e         cur_net,
    input  logic [W-1:0] rss_wide,
    input  logic [W-1:0] rss_local,
    output logic         fire
);
    always_comb begin
        if (cur_net == NET_WIDE) fire = (rss_local > rss_wide);
        else                     fire = (rss_wide > rss_local);
    end
endmodule

// File: rtl/hv_veto.sv
module hv_veto
    import hv_pkg::*;
#(
    parameter int W               = MW,
    parameter int LOCAL_MAX_SPEED = 60,
    parameter int BATT_LOW        = 64,
    parameter int LOCAL_RSS_LIMIT = 40
) (
    input  net_e         cur_net,
    input  logic [W-1:0] speed,
    input  logic [W-1:0] battery,
    input  logic [W-1:0] rss_local,
    output logic         veto
);
    localparam logic [W-1:0] SPEED_LIM = W'(LOCAL_MAX_SPEED);
    localparam logic [W-1:0] BATT_LIM  = W'(BATT_LOW);
    localparam logic [W-1:0] RSS_LIM   = W'(LOCAL_RSS_LIMIT);

    logic leave_ok;
    assign leave_ok = (battery < BATT_LIM) && (rss_local < RSS_LIM);

    always_comb begin
        if (cur_net == NET_WIDE) veto = (speed > SPEED_LIM);
        else                     veto = !leave_ok;
    end
endmodule

// File: rtl/hv_scorer.sv
module hv_scorer
    import hv_pkg::*;
#(
    parameter int N  = METRIC_N,
    parameter int SW = SCORE_W
) (
    input  logic [N-1:0]   local_better,
    input  app_e           cls,
    input  logic [MW-1:0]  battery,
    output logic [SW-1:0]  score_local,
    output logic [SW-1:0]  score_wide
);
    logic [SW-1:0] part_l [N];
    logic [SW-1:0] part_w [N];

    for (genvar g = 0; g < N; g++) begin : g_metric
        logic [WEIGHT_W-1:0] w;
        assign w         = metric_weight(g, cls, battery);
        assign part_l[g] = local_better[g] ? SW'(w) : '0;
        assign part_w[g] = local_better[g] ? '0 : SW'(w);
    end

    always_comb begin
        score_local = '0;
        score_wide  = '0;
        for (int i = 0; i < N; i++) begin
            score_local = score_local + part_l[i];
            score_wide  = score_wide + part_w[i];
        end
    end
endmodule

// File: rtl/handover_decider.sv
module handover_decider
    import hv_pkg::*;
#(
    parameter int LOCAL_MAX_SPEED = 60,
    parameter int BATT_LOW        = 64,
    parameter int LOCAL_RSS_LIMIT = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eval_start,
    input  logic [MW-1:0]       rss_wide,
    input  logic [MW-1:0]       rss_local,
    input  logic [MW-1:0]       speed,
    input  logic [MW-1:0]       battery,
    input  logic [METRIC_N-1:0] local_better,
    input  logic [2:0]          app_class,
    output logic                on_local,
    output logic                ho_cmd,
    output logic                ho_cancel
);
    state_e  state_q;
    sample_t smp_q;
    sample_t smp_d;
    net_e    net_q;
    logic    fire_q, veto_q, cmd_q, cancel_q;
    logic    fire, veto, win, scoring;
    logic [SCORE_W-1:0] sc_local, sc_wide;

    assign smp_d = '{rss_wide: rss_wide, rss_local: rss_local, speed: speed,
                     battery: battery, local_better: local_better,
                     cls: app_e'(app_class)};

    hv_trigger #(.W(MW)) i_trig (
        .cur_net(net_q), .rss_wide(smp_q.rss_wide),
        .rss_local(smp_q.rss_local), .fire(fire)
    );

    hv_veto #(
        .W(MW), .LOCAL_MAX_SPEED(LOCAL_MAX_SPEED),
        .BATT_LOW(BATT_LOW), .LOCAL_RSS_LIMIT(LOCAL_RSS_LIMIT)
    ) i_veto (
        .cur_net(net_q), .speed(smp_q.speed), .battery(smp_q.battery),
        .rss_local(smp_q.rss_local), .veto(veto)
    );

    hv_scorer #(.N(METRIC_N), .SW(SCORE_W)) i_score (
        .local_better(smp_q.local_better), .cls(smp_q.cls),
        .battery(smp_q.battery), .score_local(sc_local), .score_wide(sc_wide)
    );

    assign win     = (net_q == NET_WIDE) ? (sc_local > sc_wide) : (sc_wide > sc_local);
    assign scoring = (state_q == ST_SCORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            smp_q    <= '0;
            net_q    <= NET_WIDE;
            fire_q   <= 1'b0;
            veto_q   <= 1'b0;
            cmd_q    <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            cmd_q    <= 1'b0;
            cancel_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (eval_start) begin
                        smp_q   <= smp_d;
                        state_q <= ST_TRIG;
                    end
                end
                ST_TRIG: begin
                    fire_q  <= fire;
                    state_q <= ST_VETO;
                end
                ST_VETO: begin
                    veto_q  <= veto;
                    state_q <= ST_SCORE;
                end
                ST_SCORE: begin
                    if (fire_q && veto_q) begin
                        cancel_q <= 1'b1;
                    end else if (fire_q && win) begin
                        cmd_q <= 1'b1;
                        net_q <= (net_q == NET_WIDE) ? NET_LOCAL : NET_WIDE;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign on_local  = (net_q == NET_LOCAL);
    assign ho_cmd    = cmd_q;
    assign ho_cancel = cancel_q;
endmodule

// File: rtl/hv_checker.sv
module hv_checker (
    input logic clk,
    input logic rst,
    input logic on_local,
    input logic ho_cmd,
    input logic ho_cancel,
    input logic in_score
);
    // R5
    cmd_cancel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ho_cmd && ho_cancel));

    // R9
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ho_cmd |=> !ho_cmd);

    // R9
    cancel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ho_cancel |=> !ho_cancel);

    // R5
    net_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ho_cmd |-> (on_local != $past(on_local)));

    // R6
    net_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ho_cmd |-> $stable(on_local));

    // R9
    result_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ho_cmd || ho_cancel) |-> $past(in_score));
endmodule

bind handover_decider hv_checker i_hv_checker (
    .clk(clk), .rst(rst), .on_local(on_local), .ho_cmd(ho_cmd),
    .ho_cancel(ho_cancel), .in_score(scoring)
);

// File: tb/test_handover_decider.sv
module test_handover_decider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eval_start = 1'b0;
    logic [7:0] rss_wide = '0, rss_local = '0, speed = '0, battery = '0;
    logic [5:0] local_better = '0;
    logic [2:0] app_class = '0;
    logic       on_local, ho_cmd, ho_cancel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic exp_net = 1'b0;

    always #5 clk = ~clk;

    handover_decider i_handover_decider (
        .clk(clk), .rst(rst), .eval_start(eval_start), .rss_wide(rss_wide),
        .rss_local(rss_local), .speed(speed), .battery(battery),
        .local_better(local_better), .app_class(app_class),
        .on_local(on_local), .ho_cmd(ho_cmd), .ho_cancel(ho_cancel)
    );

    // {rss_wide, rss_local, speed, battery, local_better, app_class}
    localparam int NV = 15;
    localparam logic [40:0] VEC [NV] = '{
        {8'd50, 8'd40, 8'd10,  8'd200, 6'b000000, 3'd0}, // R1 no trigger
        {8'd50, 8'd80, 8'd100, 8'd200, 6'b111111, 3'd0}, // R2 speed veto
        {8'd50, 8'd80, 8'd60,  8'd200, 6'b111111, 3'd0}, // R2 limit, R5 move
        {8'd90, 8'd30, 8'd10,  8'd200, 6'b000000, 3'd0}, // R4 battery high
        {8'd90, 8'd30, 8'd10,  8'd30,  6'b000000, 3'd0}, // R4 proceed
        {8'd50, 8'd80, 8'd10,  8'd200, 6'b101000, 3'd3}, // R6 tie 8/8
        {8'd50, 8'd80, 8'd10,  8'd100, 6'b101000, 3'd3}, // R8 power 7
        {8'd90, 8'd50, 8'd10,  8'd30,  6'b000000, 3'd0}, // R4 local rss
        {8'd90, 8'd30, 8'd200, 8'd30,  6'b000000, 3'd0}, // R4 speed ignored
        {8'd50, 8'd80, 8'd10,  8'd200, 6'b000111, 3'd0}, // R7 default loses
        {8'd50, 8'd80, 8'd10,  8'd200, 6'b000111, 3'd2}, // R7 video wins
        {8'd50, 8'd50, 8'd10,  8'd30,  6'b000000, 3'd0}, // R3 equal
        {8'd40, 8'd90, 8'd10,  8'd30,  6'b111111, 3'd0}, // R3 wrong side
        {8'd90, 8'd30, 8'd10,  8'd30,  6'b011101, 3'd1}, // R7 voice tie
        {8'd90, 8'd30, 8'd10,  8'd30,  6'b011101, 3'd4}  // R7 idle wins
    };

    function automatic int wgt(input int idx, input logic [2:0] cls, input logic [7:0] bt);
        int r, d, j;
        case (cls)
            3'd1:    begin r = 3; d = 4; j = 4; end
            3'd2:    begin r = 4; d = 4; j = 4; end
            3'd3:    begin r = 2; d = 2; j = 1; end
            3'd4:    begin r = 1; d = 1; j = 1; end
            default: begin r = 3; d = 4; j = 3; end
        endcase
        case (idx)
            0: return r;
            1: return d;
            2: return j;
            3, 4: return 3;
            default: return (bt < 64) ? 9 : ((bt < 128) ? 7 : 5);
        endcase
    endfunction

    // returns {cmd, cancel}
    function automatic logic [1:0] model(input logic cur, input logic [40:0] v);
        logic [7:0] rw, rl, sp, bt;
        logic [5:0] bits;
        logic [2:0] cls;
        int sl, sw;
        logic fire, veto, win;
        {rw, rl, sp, bt, bits, cls} = v;
        sl = 0; sw = 0;
        for (int i = 0; i < 6; i++) begin
            if (bits[i]) sl += wgt(i, cls, bt);
            else         sw += wgt(i, cls, bt);
        end
        fire = cur ? (rw > rl) : (rl > rw);
        veto = cur ? !((bt < 64) && (rl < 40)) : (sp > 60);
        win  = cur ? (sw > sl) : (sl > sw);
        if (!fire)     return 2'b00;
        else if (veto) return 2'b01;
        else if (win)  return 2'b10;
        else           return 2'b00;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic run_eval(input logic [40:0] v, input int idx);
        logic [1:0] e;
        string tag;
        e = model(exp_net, v);
        tag = $sformatf("R5/R9 vec%0d", idx);
        @(negedge clk);
        {rss_wide, rss_local, speed, battery, local_better, app_class} = v;
        eval_start = 1'b1;
        @(negedge clk);               // edge k passed
        eval_start = 1'b0;
        @(negedge clk);               // k+1
        @(negedge clk);               // k+2
        check("R9", $sformatf("vec%0d cmd early", idx), ho_cmd, 1'b0);
        check("R9", $sformatf("vec%0d cancel early", idx), ho_cancel, 1'b0);
        @(negedge clk);               // k+3
        if (e[1]) exp_net = ~exp_net;
        check(tag, "ho_cmd", ho_cmd, e[1]);
        check(tag, "ho_cancel", ho_cancel, e[0]);
        check(tag, "on_local", on_local, exp_net);
        @(negedge clk);               // k+4
        check("R9", $sformatf("vec%0d cmd width", idx), ho_cmd, 1'b0);
        check("R9", $sformatf("vec%0d cancel width", idx), ho_cancel, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int ncancel;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "on_local", on_local, 1'b0);
        check("R11", "ho_cmd", ho_cmd, 1'b0);
        check("R11", "ho_cancel", ho_cancel, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_eval(VEC[i], i);

        // R10: request held high through edges k..k+2 gives one result only
        check("R10", "start on wide", on_local, 1'b0);
        @(negedge clk);
        {rss_wide, rss_local, speed, battery, local_better, app_class} = VEC[1];
        eval_start = 1'b1;
        repeat (3) @(negedge clk);
        eval_start = 1'b0;
        ncancel = 0;
        for (int c = 0; c < 10; c++) begin
            if (ho_cancel) ncancel++;
            @(negedge clk);
        end
        checks++;
        if (ncancel != 1) begin
            errors++;
            $display("FAIL R10 cancel pulses actual=%0d expected=1", ncancel);
        end

        // R11: reset after a handover returns to wide
        run_eval(VEC[2], 99);
        check("R11", "on local before reset", on_local, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        exp_net = 1'b0;
        check("R11", "on_local after reset", on_local, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule